// File: doc/BRIEF.md
# Priority-Masked Interrupt Request Gate

This block is the per-source front end of an interrupt controller. Every source owns a 3-bit priority field and a 1-bit enable bit, both held in a small register file that sits on a simple byte-wide register bus. On each cycle the block looks at the sources' pending flags and picks one candidate to present to the CPU. A candidate must be pending and enabled, and its priority must be strictly above the CPU's current interrupt level. Among the candidates, the one with the highest priority wins. Among candidates of equal priority, the lowest-numbered one wins. The request, the winner's index and the winner's priority are registered once before they leave the block.

The same enable bits also qualify each pending flag for use outside the interrupt path. The block drives one enable-qualified trigger per source for DMA, and a single OR of all of them for standby wake-up. Neither of these outputs depends on priority or on the CPU level. The enable bits clear on reset. The priority fields are not reset, so software must program a source's priority before it enables that source.

Top module: `irq_prio_gate`

## Requirements
- R1: After reset every enable bit is 0, so the enable byte at address 0x10 reads 0x00, and irq_req, dma_trig and wake_any stay 0 even when every source is pending.
- R2: Source i's priority is written and read at address i (0 ≤ i < NUM_SRC) in data bits [2:0]. Writes ignore bits [7:3], and reads return 0 in bits [7:3].
- R3: The enable bit of source 8k+j lives at address 0x10+k, bit j. A write stores the byte, a read returns the stored bits, and an enable bit changes only on a write to its own byte.
- R4: A source takes part in arbitration only when it is pending, its enable bit is 1, and its priority is strictly greater than cpu_level. A priority equal to the level is masked, so a priority of 0 never requests.
- R5: Among the sources that take part, the one with the highest priority wins. On a tie, the lowest index wins. irq_src carries the winner's index and irq_prio carries its priority.
- R6: irq_req, irq_src and irq_prio reflect the inputs and register contents present at the previous rising clock edge. When no source takes part, all three are 0.
- R7: dma_trig[i] is src_pend[i] AND enable bit i, combinationally. It does not depend on priority or cpu_level.
- R8: wake_any is 1 exactly when some dma_trig bit is 1, combinationally. It does not depend on priority or cpu_level.
- R9: A write to an address that maps to no register (NUM_SRC..0x0F, or 0x11 and above for 8 sources) changes no register, and a read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| src_pend | input | NUM_SRC | Pending flags of the sources |
| cpu_level | input | 3 | Current interrupt level of the CPU |
| irq_req | output | 1 | Registered interrupt request |
| irq_src | output | IDX_W | Registered index of the winning source |
| irq_prio | output | 3 | Registered priority of the winning source |
| dma_trig | output | NUM_SRC | Enable-qualified pending flags for DMA triggering |
| wake_any | output | 1 | Any enable-qualified pending flag, for standby wake-up |

## Verification
The selection logic is tried with several input patterns, each aimed at a different rule:
- A single pending source is swept through levels below, equal to and above its priority. This separates a strict comparison from a non-strict one.
- Sets of pending sources with distinct priorities check that the higher priority wins over the lower index.
- Sets with tied priorities check that the lowest index wins.
- Pending sources with their enable cleared, and sources at priority 0 with level 0, check the masking paths.
- A level of 7 keeps the interrupt path silent while dma_trig and wake_any are compared with pending AND enable. This shows that those outputs ignore priority.
- Sampling just after an input change, before the next edge, shows the one-cycle register stage on the request outputs.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int PRIO_W  = 3;
  localparam int DATA_W  = 8;
  localparam int EN_BASE = 16;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_sync_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  byte_t              reg_wdata,
  output byte_t              reg_rdata,
  output prio_t              prio_q [NUM_SRC],
  output logic [NUM_SRC-1:0] en_q
);
  localparam int EN_BYTES = (NUM_SRC + DATA_W - 1) / DATA_W;

  prio_t              prio_d  [NUM_SRC];
  logic [NUM_SRC-1:0] prio_ce;
  logic [NUM_SRC-1:0] en_d;
  logic               en_ce;

  // Priority fields: per-entry clock enable, no reset (value undefined until written)
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      prio_ce[i] = reg_wr && (reg_addr == ADDR_W'(i));
      prio_d[i]  = reg_wdata[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    always_ff @(posedge clk) begin
      if (prio_ce[g]) prio_q[g] <= prio_d[g];
    end
  end

  // Enable bits: byte-addressed, reset to zero
  always_comb begin
    en_d  = en_q;
    en_ce = 1'b0;
    for (int k = 0; k < EN_BYTES; k++) begin
      if (reg_wr && (reg_addr == ADDR_W'(EN_BASE + k))) begin
        en_ce = 1'b1;
        for (int j = 0; j < DATA_W; j++) begin
          if (k * DATA_W + j < NUM_SRC) en_d[k*DATA_W+j] = reg_wdata[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  en_q <= '0;
    else if (en_ce)   en_q <= en_d;
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata[PRIO_W-1:0] = prio_q[i];
    end
    for (int k = 0; k < EN_BYTES; k++) begin
      if (reg_addr == ADDR_W'(EN_BASE + k)) begin
        for (int j = 0; j < DATA_W; j++) begin
          if (k * DATA_W + j < NUM_SRC) reg_rdata[j] = en_q[k*DATA_W+j];
        end
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] src_pend,
  input  logic [NUM_SRC-1:0] en,
  input  prio_t              prio [NUM_SRC],
  input  prio_t              cpu_level,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output prio_t              win_prio
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = src_pend[g] && en[g] && (prio[g] > cpu_level);
  end

  // Scan from index 0 upward; only a strictly higher priority replaces the
  // current best, so the lowest index keeps a tie.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_valid || (prio[i] > win_prio))) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [NUM_SRC-1:0] src_pend,
  input  logic [2:0]         cpu_level,
  output logic               irq_req,
  output logic [IDX_W-1:0]   irq_src,
  output logic [2:0]         irq_prio,
  output logic [NUM_SRC-1:0] dma_trig,
  output logic               wake_any
);
  logic               rst_sync_n;
  prio_t              prio_q [NUM_SRC];
  logic [NUM_SRC-1:0] en_q;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  prio_t              win_prio;

  logic               req_q, req_d;
  logic [IDX_W-1:0]   src_q, src_d;
  prio_t              pri_q, pri_d;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .prio_q     (prio_q),
    .en_q       (en_q)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .src_pend  (src_pend),
    .en        (en_q),
    .prio      (prio_q),
    .cpu_level (cpu_level),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  always_comb begin
    req_d = win_valid;
    src_d = win_valid ? win_idx  : '0;
    pri_d = win_valid ? win_prio : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= 1'b0;
      src_q <= '0;
      pri_q <= '0;
    end else begin
      req_q <= req_d;
      src_q <= src_d;
      pri_q <= pri_d;
    end
  end

  assign irq_req  = req_q;
  assign irq_src  = src_q;
  assign irq_prio = pri_q;
  assign dma_trig = src_pend & en_q;
  assign wake_any = |dma_trig;
endmodule

// File: rtl/irq_prio_gate_chk.sv
module irq_prio_gate_chk #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [NUM_SRC-1:0] src_pend,
  input logic [2:0]         cpu_level,
  input logic               irq_req,
  input logic [IDX_W-1:0]   irq_src,
  input logic [2:0]         irq_prio,
  input logic [NUM_SRC-1:0] dma_trig,
  input logic               wake_any,
  input logic [NUM_SRC-1:0] en
);
  AST_REQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_prio > $past(cpu_level))); // R4

  AST_REQ_SRC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (((($past(src_pend) & $past(en)) >> irq_src) & NUM_SRC'(1)) != '0)); // R4

  AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_src == '0 && irq_prio == '0)); // R6

  AST_DMA_NEEDS_PEND_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_trig & ~(src_pend & en)) == '0)); // R7

  AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any |-> (src_pend != '0)); // R8

  AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> $stable(en)); // R3

  AST_EN_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr) && $past(reg_addr) != ADDR_W'(16)) |-> $stable(en)); // R9
endmodule

bind irq_prio_gate irq_prio_gate_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .src_pend  (src_pend),
  .cpu_level (cpu_level),
  .irq_req   (irq_req),
  .irq_src   (irq_src),
  .irq_prio  (irq_prio),
  .dma_trig  (dma_trig),
  .wake_any  (wake_any),
  .en        (en_q)
);

// File: tb/irq_prio_gate_test.sv
module irq_prio_gate_test;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [N-1:0] src_pend;
  logic [2:0] cpu_level;
  logic       irq_req;
  logic [2:0] irq_src;
  logic [2:0] irq_prio;
  logic [N-1:0] dma_trig;
  logic       wake_any;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [2:0]   m_prio [N];
  logic [N-1:0] m_en;

  always #5 clk = ~clk;

  irq_prio_gate uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pend(src_pend),
    .cpu_level(cpu_level), .irq_req(irq_req), .irq_src(irq_src),
    .irq_prio(irq_prio), .dma_trig(dma_trig), .wake_any(wake_any)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a < N) m_prio[a] = d[2:0];
    else if (a == 8'h10) m_en = d;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, $sformatf("read 0x%0h", a), 32'(reg_rdata), 32'(exp));
  endtask

  // Drive pend/level at a falling edge, sample registered outputs one edge later
  task automatic apply_and_check(input string req, input logic [N-1:0] p, input logic [2:0] lvl);
    logic       e_req;
    logic [2:0] e_src, e_pri;
    src_pend = p; cpu_level = lvl;
    e_req = 1'b0; e_src = '0; e_pri = '0;
    for (int i = 0; i < N; i++) begin
      if (p[i] && m_en[i] && (m_prio[i] > lvl) && (!e_req || m_prio[i] > e_pri)) begin
        e_req = 1'b1; e_src = 3'(i); e_pri = m_prio[i];
      end
    end
    @(negedge clk);
    chk(req, "irq_req",  32'(irq_req),  32'(e_req));
    chk(req, "irq_src",  32'(irq_src),  32'(e_src));
    chk(req, "irq_prio", 32'(irq_prio), 32'(e_pri));
  endtask

  task automatic t_reset;
    rd_chk("R1", 8'h10, 8'h00);
    src_pend = '1; cpu_level = 3'd0;
    #1;
    chk("R1", "dma_trig after reset", 32'(dma_trig), 32'(0));
    chk("R1", "wake_any after reset", 32'(wake_any), 32'(0));
    @(negedge clk);
    chk("R1", "irq_req after reset", 32'(irq_req), 32'(0));
    src_pend = '0;
  endtask

  task automatic t_regs;
    for (int i = 0; i < N; i++) wr(8'(i), 8'(8'hF8 | ((i * 3) % 8)));
    for (int i = 0; i < N; i++) rd_chk("R2", 8'(i), 8'((i * 3) % 8));
    wr(8'h10, 8'hA5);
    rd_chk("R3", 8'h10, 8'hA5);
    wr(8'h10, 8'h5A);
    rd_chk("R3", 8'h10, 8'h5A);
  endtask

  task automatic t_unmapped;
    wr(8'h08, 8'hFF);
    wr(8'h0F, 8'hFF);
    wr(8'h11, 8'hFF);
    wr(8'h80, 8'h00);
    rd_chk("R9", 8'h08, 8'h00);
    rd_chk("R9", 8'h11, 8'h00);
    for (int i = 0; i < N; i++) rd_chk("R9", 8'(i), 8'(m_prio[i]));
    rd_chk("R9", 8'h10, m_en);
  endtask

  task automatic t_level;
    wr(8'h03, 8'h04);
    wr(8'h10, 8'hFF);
    apply_and_check("R4", 8'b0000_1000, 3'd3);  // 4 > 3: request
    chk("R4", "src3 selected", 32'(irq_src), 32'(3));
    apply_and_check("R4", 8'b0000_1000, 3'd4);  // equal: masked
    chk("R4", "equal level masked", 32'(irq_req), 32'(0));
    apply_and_check("R4", 8'b0000_1000, 3'd5);
    apply_and_check("R4", 8'b0000_1000, 3'd0);
    wr(8'h00, 8'h00);                           // priority 0 at level 0
    apply_and_check("R4", 8'b0000_0001, 3'd0);
    chk("R4", "prio 0 never requests", 32'(irq_req), 32'(0));
    wr(8'h10, 8'hF7);                           // disable source 3
    apply_and_check("R4", 8'b0000_1000, 3'd0);
    chk("R4", "disabled source masked", 32'(irq_req), 32'(0));
    wr(8'h10, 8'hFF);
  endtask

  task automatic t_pick;
    wr(8'h00, 8'h02); wr(8'h01, 8'h05); wr(8'h02, 8'h05); wr(8'h03, 8'h07);
    wr(8'h04, 8'h01); wr(8'h05, 8'h06); wr(8'h06, 8'h06); wr(8'h07, 8'h03);
    apply_and_check("R5", 8'b0000_0110, 3'd0);
    chk("R5", "tie lowest index", 32'(irq_src), 32'(1));
    apply_and_check("R5", 8'b1111_1111, 3'd0);
    chk("R5", "highest prio wins", 32'(irq_src), 32'(3));
    apply_and_check("R5", 8'b1110_0000, 3'd2);
    chk("R5", "tie 5/6 lowest", 32'(irq_src), 32'(5));
    apply_and_check("R5", 8'b1001_0001, 3'd1);
    chk("R5", "high index higher prio", 32'(irq_src), 32'(7));
    apply_and_check("R5", 8'b0000_0001, 3'd2);
    apply_and_check("R5", 8'b0000_0001, 3'd1);
  endtask

  task automatic t_latency;
    apply_and_check("R6", 8'b0000_1000, 3'd0);
    src_pend = '0;
    #1;
    chk("R6", "req held until edge", 32'(irq_req), 32'(1));
    @(negedge clk);
    chk("R6", "idle req", 32'(irq_req), 32'(0));
    chk("R6", "idle src", 32'(irq_src), 32'(0));
    chk("R6", "idle prio", 32'(irq_prio), 32'(0));
  endtask

  task automatic t_dma_wake;
    wr(8'h10, 8'h3C);
    src_pend = 8'b1010_0110; cpu_level = 3'd7;
    #1;
    chk("R7", "dma_trig", 32'(dma_trig), 32'(8'b0010_0100));
    chk("R8", "wake_any set", 32'(wake_any), 32'(1));
    @(negedge clk);
    chk("R7", "no irq at level 7", 32'(irq_req), 32'(0));
    src_pend = 8'b1100_0011;
    #1;
    chk("R7", "dma_trig masked", 32'(dma_trig), 32'(0));
    chk("R8", "wake_any clear", 32'(wake_any), 32'(0));
    src_pend = '0;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    src_pend = '0; cpu_level = '0; m_en = '0;
    for (int i = 0; i < N; i++) m_prio[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_level();
    t_pick();
    t_latency();
    t_dma_wake();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule